// File: doc/BRIEF.md
# Decode-Stage Operand Forwarding Selector

This block sits at the end of the decode stage of an in-order five-stage pipeline and produces the two source operand values. Each operand is picked from the register-file read data or from a result that an older instruction has computed but not yet committed: the ALU result leaving execute, the ALU result or loaded data held in the memory stage, and the ALU result or loaded data held in write-back. The choice follows a fixed priority so that the decode stage always sees the value the most recent older writer would have left, matching sequential program order.

The ALU destination and the load destination of each stage are compared with the decode source ID separately. The all-ones register ID means "no register": it never matches, so an instruction without a given operand, or a conditional move whose condition failed (which reports the all-ones destination), neither causes nor receives forwarding. For call and jump instructions operand A carries the incremented PC instead of any register value. The selector is purely combinational; the register file and stall detection live elsewhere.

Top module: `fwd_sel_top`

## Requirements
- R1: When `dec_kind_i` is 2'b01 (call) or 2'b10 (jump), `opnd_a_o` equals `dec_next_pc_i` regardless of any ID match.
- R2: When `dec_kind_i` is 2'b00 or 2'b11, `dec_next_pc_i` has no effect on `opnd_a_o`.
- R3: A source ID equal to `ex_dst_alu_i` selects `ex_alu_val_i` over every other forwarding source.
- R4: Within the memory stage, a match on `mem_dst_ld_i` selects `mem_ld_val_i` over a simultaneous match on `mem_dst_alu_i`.
- R5: A memory-stage match (either kind) wins over any write-back-stage match.
- R6: Within write-back, a match on `wb_dst_ld_i` selects `wb_ld_val_i` over a simultaneous match on `wb_dst_alu_i`, and a lone `wb_dst_alu_i` match selects `wb_alu_val_i`.
- R7: With no destination matching, the operand equals the register-file value (`rf_a_val_i` / `rf_b_val_i`).
- R8: A source ID of 4'hF never matches, so the operand equals the register-file value even when destinations are also 4'hF.
- R9: A destination of 4'hF (no write, or a failed conditional move) is never forwarded to a real source ID.
- R10: `opnd_b_o` follows the same priority as operand A but never takes the incremented PC, whatever `dec_kind_i` is.
- R11: Operands A and B are selected independently; each may forward from a different stage in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src_a_i | input | 4 | Decode source ID for operand A (4'hF = none) |
| dec_src_b_i | input | 4 | Decode source ID for operand B (4'hF = none) |
| dec_kind_i | input | 2 | Decode instruction class: 01 call, 10 jump, 00/11 other |
| dec_next_pc_i | input | 64 | Incremented PC of the decode instruction |
| ex_dst_alu_i | input | 4 | Execute-stage ALU destination ID |
| ex_alu_val_i | input | 64 | Execute-stage ALU result |
| mem_dst_alu_i | input | 4 | Memory-stage ALU destination ID |
| mem_dst_ld_i | input | 4 | Memory-stage load destination ID |
| mem_alu_val_i | input | 64 | Memory-stage ALU result |
| mem_ld_val_i | input | 64 | Memory-stage loaded data |
| wb_dst_alu_i | input | 4 | Write-back ALU destination ID |
| wb_dst_ld_i | input | 4 | Write-back load destination ID |
| wb_alu_val_i | input | 64 | Write-back ALU result |
| wb_ld_val_i | input | 64 | Write-back loaded data |
| rf_a_val_i | input | 64 | Register-file read data for operand A |
| rf_b_val_i | input | 64 | Register-file read data for operand B |
| opnd_a_o | output | 64 | Selected operand A |
| opnd_b_o | output | 64 | Selected operand B |

## Verification
The assertions check continuously that the PC override wins for call and jump, that a "none" source always falls back to register-file data, that an execute-stage match always delivers the execute result, and that operand B ignores the instruction class. The ordering between the lower-priority sources (memory load over memory ALU, memory over write-back, write-back load over write-back ALU) and the rejection of all-ones destinations are shown only by bench scenarios that line up several matching destinations at once, plus a long run of random ID collisions compared with a behavioural model.

// File: rtl/fwd_sel_pkg.sv
package fwd_sel_pkg;

  localparam int OPND_W = 64;
  localparam int REG_ID_W = 4;

  // forwarding sources, index 0 is the youngest and wins
  typedef enum int unsigned {
    SRC_EX_ALU  = 0,
    SRC_MEM_LD  = 1,
    SRC_MEM_ALU = 2,
    SRC_WB_LD   = 3,
    SRC_WB_ALU  = 4,
    SRC_COUNT   = 5
  } fwd_src_e;

  typedef enum logic [1:0] {
    KIND_PLAIN = 2'b00,
    KIND_CALL  = 2'b01,
    KIND_JUMP  = 2'b10,
    KIND_MISC  = 2'b11
  } dec_kind_e;

endpackage

// File: rtl/fwd_hit.sv
module fwd_hit #(
  parameter int ID_W = 4
) (
  input  logic [ID_W-1:0] src_i,
  input  logic [ID_W-1:0] dst_i,
  output logic            hit_o
);
  localparam logic [ID_W-1:0] NONE_ID = {ID_W{1'b1}};

  assign hit_o = (src_i != NONE_ID) && (src_i == dst_i);
endmodule

// File: rtl/fwd_chain.sv
module fwd_chain #(
  parameter int DATA_W = 64,
  parameter int N      = 5
) (
  input  logic [N-1:0]             hit_i,
  input  logic [N-1:0][DATA_W-1:0] val_i,
  input  logic [DATA_W-1:0]        fallback_i,
  output logic [DATA_W-1:0]        sel_o
);
  // walk from oldest to youngest so the lowest index overrides
  always_comb begin
    sel_o = fallback_i;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_i[i]) sel_o = val_i[i];
    end
  end
endmodule

// File: rtl/fwd_operand.sv
module fwd_operand #(
  parameter int DATA_W = 64,
  parameter int ID_W   = 4,
  parameter int N      = 5
) (
  input  logic [ID_W-1:0]          src_i,
  input  logic                     pc_sel_i,
  input  logic [DATA_W-1:0]        pc_i,
  input  logic [N-1:0][ID_W-1:0]   dst_i,
  input  logic [N-1:0][DATA_W-1:0] val_i,
  input  logic [DATA_W-1:0]        rf_i,
  output logic [DATA_W-1:0]        opnd_o
);
  localparam logic [ID_W-1:0] NONE_ID = {ID_W{1'b1}};

  logic [N-1:0]      hit;
  logic [DATA_W-1:0] fwd_val;

  for (genvar g = 0; g < N; g++) begin : g_hit
    fwd_hit #(.ID_W(ID_W)) u_hit (
      .src_i (src_i),
      .dst_i (dst_i[g]),
      .hit_o (hit[g])
    );
  end

  fwd_chain #(.DATA_W(DATA_W), .N(N)) u_chain (
    .hit_i      (hit),
    .val_i      (val_i),
    .fallback_i (rf_i),
    .sel_o      (fwd_val)
  );

  assign opnd_o = pc_sel_i ? pc_i : fwd_val;

  always_comb begin
    if (!pc_sel_i && src_i == NONE_ID) begin
      AST_NONE_TO_RF: assert (opnd_o == rf_i) else $error("none source not from rf"); // R8
    end
    if (!pc_sel_i && src_i != NONE_ID && src_i == dst_i[0]) begin
      AST_YOUNGEST_WINS: assert (opnd_o == val_i[0]) else $error("youngest source lost"); // R3
    end
  end
endmodule

// File: rtl/fwd_sel_top.sv
module fwd_sel_top
  import fwd_sel_pkg::*;
#(
  parameter int DATA_W = OPND_W,
  parameter int ID_W   = REG_ID_W
) (
  input  logic [ID_W-1:0]   dec_src_a_i,
  input  logic [ID_W-1:0]   dec_src_b_i,
  input  logic [1:0]        dec_kind_i,
  input  logic [DATA_W-1:0] dec_next_pc_i,
  input  logic [ID_W-1:0]   ex_dst_alu_i,
  input  logic [DATA_W-1:0] ex_alu_val_i,
  input  logic [ID_W-1:0]   mem_dst_alu_i,
  input  logic [ID_W-1:0]   mem_dst_ld_i,
  input  logic [DATA_W-1:0] mem_alu_val_i,
  input  logic [DATA_W-1:0] mem_ld_val_i,
  input  logic [ID_W-1:0]   wb_dst_alu_i,
  input  logic [ID_W-1:0]   wb_dst_ld_i,
  input  logic [DATA_W-1:0] wb_alu_val_i,
  input  logic [DATA_W-1:0] wb_ld_val_i,
  input  logic [DATA_W-1:0] rf_a_val_i,
  input  logic [DATA_W-1:0] rf_b_val_i,
  output logic [DATA_W-1:0] opnd_a_o,
  output logic [DATA_W-1:0] opnd_b_o
);
  localparam int N = int'(SRC_COUNT);
  localparam logic [ID_W-1:0] NONE_ID = {ID_W{1'b1}};

  logic [N-1:0][ID_W-1:0]   dst;
  logic [N-1:0][DATA_W-1:0] val;
  logic                     a_pc_sel;

  // order of the arrays is the forwarding priority
  always_comb begin
    dst[SRC_EX_ALU]  = ex_dst_alu_i;   val[SRC_EX_ALU]  = ex_alu_val_i;
    dst[SRC_MEM_LD]  = mem_dst_ld_i;   val[SRC_MEM_LD]  = mem_ld_val_i;
    dst[SRC_MEM_ALU] = mem_dst_alu_i;  val[SRC_MEM_ALU] = mem_alu_val_i;
    dst[SRC_WB_LD]   = wb_dst_ld_i;    val[SRC_WB_LD]   = wb_ld_val_i;
    dst[SRC_WB_ALU]  = wb_dst_alu_i;   val[SRC_WB_ALU]  = wb_alu_val_i;
  end

  assign a_pc_sel = (dec_kind_i == KIND_CALL) || (dec_kind_i == KIND_JUMP);

  fwd_operand #(.DATA_W(DATA_W), .ID_W(ID_W), .N(N)) u_opnd_a (
    .src_i    (dec_src_a_i),
    .pc_sel_i (a_pc_sel),
    .pc_i     (dec_next_pc_i),
    .dst_i    (dst),
    .val_i    (val),
    .rf_i     (rf_a_val_i),
    .opnd_o   (opnd_a_o)
  );

  fwd_operand #(.DATA_W(DATA_W), .ID_W(ID_W), .N(N)) u_opnd_b (
    .src_i    (dec_src_b_i),
    .pc_sel_i (1'b0),
    .pc_i     (dec_next_pc_i),
    .dst_i    (dst),
    .val_i    (val),
    .rf_i     (rf_b_val_i),
    .opnd_o   (opnd_b_o)
  );

  always_comb begin
    if (dec_kind_i == 2'b01 || dec_kind_i == 2'b10) begin
      AST_PC_OVERRIDE: assert (opnd_a_o == dec_next_pc_i) else $error("pc override lost"); // R1
    end
    if (dec_src_b_i == NONE_ID) begin
      AST_B_NO_PC: assert (opnd_b_o == rf_b_val_i) else $error("operand b not from rf"); // R10
    end
    if (dec_src_b_i != NONE_ID && dec_src_b_i == ex_dst_alu_i) begin
      AST_B_EX_FWD: assert (opnd_b_o == ex_alu_val_i) else $error("operand b missed execute"); // R11
    end
  end
endmodule

// File: tb/tb_fwd_sel_top.sv
module tb_fwd_sel_top;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [3:0]  src_a, src_b, ex_da, mem_da, mem_dl, wb_da, wb_dl;
  logic [1:0]  kind;
  logic [63:0] pc, ex_v, mem_av, mem_lv, wb_av, wb_lv, rf_a, rf_b;
  logic [63:0] opnd_a, opnd_b;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  fwd_sel_top dut (
    .dec_src_a_i   (src_a),
    .dec_src_b_i   (src_b),
    .dec_kind_i    (kind),
    .dec_next_pc_i (pc),
    .ex_dst_alu_i  (ex_da),
    .ex_alu_val_i  (ex_v),
    .mem_dst_alu_i (mem_da),
    .mem_dst_ld_i  (mem_dl),
    .mem_alu_val_i (mem_av),
    .mem_ld_val_i  (mem_lv),
    .wb_dst_alu_i  (wb_da),
    .wb_dst_ld_i   (wb_dl),
    .wb_alu_val_i  (wb_av),
    .wb_ld_val_i   (wb_lv),
    .rf_a_val_i    (rf_a),
    .rf_b_val_i    (rf_b),
    .opnd_a_o      (opnd_a),
    .opnd_b_o      (opnd_b)
  );

  // behavioural model: scan producers youngest first
  function automatic logic [63:0] model(input logic [3:0] src, input bit use_pc,
                                        input logic [63:0] rf);
    logic [3:0]  ids [5];
    logic [63:0] vals[5];
    if (use_pc && (kind == 2'b01 || kind == 2'b10)) return pc;
    if (src == 4'hF) return rf;
    ids  = '{ex_da, mem_dl, mem_da, wb_dl, wb_da};
    vals = '{ex_v, mem_lv, mem_av, wb_lv, wb_av};
    foreach (ids[i]) if (ids[i] == src) return vals[i];
    return rf;
  endfunction

  task automatic idle();
    src_a = 4'hF; src_b = 4'hF; kind = 2'b00; pc = 64'h1000;
    ex_da = 4'hF; mem_da = 4'hF; mem_dl = 4'hF; wb_da = 4'hF; wb_dl = 4'hF;
    ex_v = 64'hE0; mem_av = 64'hA1; mem_lv = 64'hD1; wb_av = 64'hA2; wb_lv = 64'hD2;
    rf_a = 64'h5A5A; rf_b = 64'hB5B5;
  endtask

  task automatic check(input string tag);
    logic [63:0] ea, eb;
    @(negedge clk);
    ea = model(src_a, 1'b1, rf_a);
    eb = model(src_b, 1'b0, rf_b);
    n_cmp++;
    if (opnd_a !== ea) begin
      n_bad++;
      $display("FAIL %s operand A: got %h expected %h", tag, opnd_a, ea);
    end
    n_cmp++;
    if (opnd_b !== eb) begin
      n_bad++;
      $display("FAIL %s operand B: got %h expected %h", tag, opnd_b, eb);
    end
    @(posedge clk);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle();
    @(posedge clk);
    check("R7 idle");

    idle(); src_a = 4'd3; kind = 2'b01; ex_da = 4'd3; pc = 64'hCA11;
    check("R1 call");
    idle(); src_a = 4'd2; kind = 2'b10; wb_da = 4'd2; pc = 64'h1234;
    check("R1 jump");
    idle(); src_a = 4'd4; kind = 2'b11; wb_da = 4'd4; pc = 64'hDEAD;
    check("R2 misc kind");
    idle(); src_a = 4'hF; kind = 2'b00; pc = 64'hBEEF;
    check("R2 plain kind");

    idle(); src_a = 4'd1; src_b = 4'd1;
    ex_da = 4'd1; mem_dl = 4'd1; mem_da = 4'd1; wb_dl = 4'd1; wb_da = 4'd1;
    check("R3 all stages match");
    idle(); src_a = 4'd6; mem_dl = 4'd6; mem_da = 4'd6;
    check("R4 mem ld over alu");
    idle(); src_b = 4'd7; mem_da = 4'd7; wb_dl = 4'd7; wb_da = 4'd7;
    check("R5 mem over wb");
    idle(); src_a = 4'd8; wb_dl = 4'd8; wb_da = 4'd8;
    check("R6 wb ld over alu");
    idle(); src_a = 4'd9; wb_da = 4'd9;
    check("R6 wb alu alone");
    idle(); src_a = 4'd5; src_b = 4'd0; ex_da = 4'd1; wb_da = 4'd2;
    check("R7 no match");
    idle(); ex_da = 4'hF; mem_dl = 4'hF; wb_da = 4'hF;
    check("R8 none source");
    idle(); src_a = 4'd0; src_b = 4'd0; ex_da = 4'hF; mem_da = 4'hF;
    check("R9 none dst");
    idle(); kind = 2'b01; src_b = 4'd2; mem_dl = 4'd2;
    check("R10 b ignores call");
    idle(); src_a = 4'd3; src_b = 4'd4; ex_da = 4'd3; wb_dl = 4'd4;
    check("R11 independent");

    for (int k = 0; k < 3000; k++) begin
      src_a  = 4'($urandom_range(0, 15) > 12 ? 15 : $urandom_range(0, 3));
      src_b  = 4'($urandom_range(0, 15) > 12 ? 15 : $urandom_range(0, 3));
      ex_da  = 4'($urandom_range(0, 4) == 4 ? 15 : $urandom_range(0, 3));
      mem_da = 4'($urandom_range(0, 4) == 4 ? 15 : $urandom_range(0, 3));
      mem_dl = 4'($urandom_range(0, 4) == 4 ? 15 : $urandom_range(0, 3));
      wb_da  = 4'($urandom_range(0, 4) == 4 ? 15 : $urandom_range(0, 3));
      wb_dl  = 4'($urandom_range(0, 4) == 4 ? 15 : $urandom_range(0, 3));
      kind   = 2'($urandom_range(0, 3));
      pc     = {$urandom, $urandom};
      ex_v   = {$urandom, $urandom};
      mem_av = {$urandom, $urandom};
      mem_lv = {$urandom, $urandom};
      wb_av  = {$urandom, $urandom};
      wb_lv  = {$urandom, $urandom};
      rf_a   = {$urandom, $urandom};
      rf_b   = {$urandom, $urandom};
      check("R3 R4 R5 R6 R10 random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule